// File: doc/BRIEF.md
# Offset-Cancelling Conversion Sequencer

This block sits between a decimation filter and the serial host interface of a delta-sigma converter. It drives the front end's input-short and input-polarity controls and turns the filter's stream of words into the final conversion results. A two-bit mode input picks one of three behaviours. With the inputs shorted, the words hold only the converter offset. With plain pass-through, the words hold signal plus offset. In cancelling mode, the block takes conversions in pairs of opposite polarity and reports half their difference, so the offset drops out.

In both pass-through modes every accepted filter word is forwarded, so results come at the filter rate. In cancelling mode the polarity alternates after every accepted word, and one result is produced per pair, which is half the filter rate. After any change of front-end configuration, a settable number of filter words (`SKIP_WORDS`) is dropped while the analog path settles. The block is a state machine with seven states: `ST_RESERVED` (reserved mode, nothing produced), `ST_PASS_SETTLE` and `ST_PASS_RUN` (pass-through modes), and `ST_POS_SETTLE`, `ST_POS_TAKE`, `ST_NEG_SETTLE` and `ST_NEG_TAKE` (cancelling mode).

The transitions are as follows:
- A mode change moves the machine to the entry state of the new mode. That is the settle state, or the run/take state when `SKIP_WORDS` is 0.
- A settle state moves on to its run/take state once the last word to be dropped arrives.
- `ST_POS_TAKE` moves to the negative entry state on an accepted word.
- `ST_NEG_TAKE` moves back to the positive entry state on an accepted word and emits a result.

Every result also raises a conversion-complete pulse for the host interrupt.

Top module: `ocs_sequencer`

## Requirements
- R1: After reset, `short_o`=1, `polarity_o`=0, `out_valid_o`=0, `irq_o`=0 and `out_word_o`=0. The internal mode is taken as the reserved code 2'b10.
- R2: In mode 2'b00, `short_o`=1 and `polarity_o`=0. After settling, each filter word appears unchanged on `out_word_o`, with `out_valid_o` high for one cycle, on the clock edge after the word was accepted.
- R3: In mode 2'b11, `short_o`=0 and `polarity_o`=0. After settling, filter words pass through unchanged, as in R2.
- R4: In mode 2'b01, `short_o`=0. `polarity_o` is 0 while a positive word is awaited and 1 while a negative word is awaited. It changes only on the edge after an accepted word, or on a mode change.
- R5: After each configuration change (a mode change, or a polarity change in mode 2'b01), the first `SKIP_WORDS` filter words are dropped and produce no output. The default is 1.
- R6: In mode 2'b01, one result is produced per pair, on the edge after the negative word. The result is floor((pos − neg + 1) / 2), with both words read as 24-bit two's complement.
- R7: A cancelled result above 2^23−1 is clamped to 24'h7FFFFF instead of wrapping. For example, pos=24'h7FFFFF and neg=24'h800000 give 24'h7FFFFF.
- R8: A change on `mode_i` discards any filter word accepted in the same cycle, along with any half-completed pair. No output appears on the following edge, and cancelling mode always restarts with `polarity_o`=0.
- R9: `irq_o` is high in exactly the cycles in which `out_valid_o` is high.
- R10: In reserved mode 2'b10, `short_o`=1, `polarity_o`=0, and filter words produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 shorted, 01 cancelling, 10 reserved, 11 pass-through |
| flt_word_i | input | 24 | Filter result word, two's complement |
| flt_valid_i | input | 1 | Filter word strobe |
| polarity_o | output | 1 | Front-end input swap (1 = swapped) |
| short_o | output | 1 | Front-end input short |
| out_word_o | output | 24 | Final conversion word |
| out_valid_o | output | 1 | Final word strobe |
| irq_o | output | 1 | Conversion-complete pulse |

## Verification
A mode change and an accepted filter word can fall in the same clock cycle. Only the mode change may take effect; the word must be dropped. The bench provokes this by driving a new `mode_i` together with `flt_valid_i` on one falling edge, both in the middle of a cancelling pair and during pass-through. It then judges the outcome by three observations: no `out_valid_o` on the next edge, `polarity_o` back at 0, and a following complete pair whose result ignores the abandoned positive word. A polarity change coinciding with the next filter word is judged by confirming that the word is dropped as settling.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

    typedef enum logic [1:0] {
        MODE_SHORT  = 2'b00,
        MODE_CANCEL = 2'b01,
        MODE_RESV   = 2'b10,
        MODE_PASS   = 2'b11
    } seq_mode_e;

    typedef enum logic [2:0] {
        ST_RESERVED    = 3'd0,
        ST_PASS_SETTLE = 3'd1,
        ST_PASS_RUN    = 3'd2,
        ST_POS_SETTLE  = 3'd3,
        ST_POS_TAKE    = 3'd4,
        ST_NEG_SETTLE  = 3'd5,
        ST_NEG_TAKE    = 3'd6
    } seq_state_e;

endpackage

// File: rtl/ocs_fsm.sv
module ocs_fsm
    import ocs_pkg::*;
#(
    parameter int SKIP_WORDS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       flt_valid_i,
    output logic       pass_take_o,
    output logic       pos_load_o,
    output logic       pair_done_o,
    output logic       polarity_o,
    output logic       short_o
);

    localparam int CNT_W = (SKIP_WORDS > 1) ? $clog2(SKIP_WORDS) : 1;
    localparam int LAST_I = (SKIP_WORDS > 0) ? SKIP_WORDS - 1 : 0;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LAST_I);
    localparam bit HAS_SETTLE = (SKIP_WORDS > 0);

    seq_state_e       state_q, state_d;
    seq_mode_e        mode_q, mode_in;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             mode_chg;
    logic             settle_last;

    assign mode_in     = seq_mode_e'(mode_i);
    assign mode_chg    = (mode_in != mode_q);
    assign settle_last = flt_valid_i && (cnt_q == LAST);

    function automatic seq_state_e entry_of(input seq_mode_e m);
        seq_state_e s;
        unique case (m)
            MODE_SHORT, MODE_PASS: s = HAS_SETTLE ? ST_PASS_SETTLE : ST_PASS_RUN;
            MODE_CANCEL:           s = HAS_SETTLE ? ST_POS_SETTLE : ST_POS_TAKE;
            default:               s = ST_RESERVED;
        endcase
        return s;
    endfunction

    // next state and settle counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (mode_chg) begin
            state_d = entry_of(mode_in);
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_RESERVED: state_d = ST_RESERVED;
                ST_PASS_SETTLE: begin
                    if (settle_last) begin
                        state_d = ST_PASS_RUN;
                        cnt_d   = '0;
                    end else if (flt_valid_i) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_PASS_RUN: state_d = ST_PASS_RUN;
                ST_POS_SETTLE: begin
                    if (settle_last) begin
                        state_d = ST_POS_TAKE;
                        cnt_d   = '0;
                    end else if (flt_valid_i) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_POS_TAKE: begin
                    if (flt_valid_i) begin
                        state_d = HAS_SETTLE ? ST_NEG_SETTLE : ST_NEG_TAKE;
                    end
                end
                ST_NEG_SETTLE: begin
                    if (settle_last) begin
                        state_d = ST_NEG_TAKE;
                        cnt_d   = '0;
                    end else if (flt_valid_i) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_NEG_TAKE: begin
                    if (flt_valid_i) begin
                        state_d = HAS_SETTLE ? ST_POS_SETTLE : ST_POS_TAKE;
                    end
                end
                default: state_d = ST_RESERVED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESERVED;
            mode_q  <= MODE_RESV;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_in;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        pass_take_o = 1'b0;
        pos_load_o  = 1'b0;
        pair_done_o = 1'b0;
        polarity_o  = 1'b0;
        short_o     = (mode_q == MODE_SHORT);
        unique case (state_q)
            ST_RESERVED:    short_o = 1'b1;
            ST_PASS_SETTLE: ;
            ST_PASS_RUN:    pass_take_o = flt_valid_i && !mode_chg;
            ST_POS_SETTLE:  ;
            ST_POS_TAKE:    pos_load_o = flt_valid_i && !mode_chg;
            ST_NEG_SETTLE:  polarity_o = 1'b1;
            ST_NEG_TAKE: begin
                polarity_o  = 1'b1;
                pair_done_o = flt_valid_i && !mode_chg;
            end
            default: short_o = 1'b1;
        endcase
    end

    AST_SWAP_ONLY_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        polarity_o |-> (mode_q == MODE_CANCEL)); // R4
    AST_SWAP_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (polarity_o != $past(polarity_o)) |-> ($past(flt_valid_i) || $past(mode_chg))); // R4
    AST_RESV_SHORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RESV) |-> (short_o && !polarity_o)); // R10

endmodule

// File: rtl/ocs_pair_math.sv
module ocs_pair_math #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pos_load_i,
    input  logic         pair_done_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] result_o
);

    localparam int XW = W + 2;
    localparam logic signed [XW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {3'b111, {(W-1){1'b0}}};

    logic [W-1:0]          pos_q;
    logic signed [XW-1:0]  diff_w;
    logic signed [XW-1:0]  half_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (pos_load_i) begin
            pos_q <= word_i;
        end
    end

    always_comb begin
        diff_w = $signed({{2{pos_q[W-1]}}, pos_q})
               - $signed({{2{word_i[W-1]}}, word_i})
               + XW'(1);
        half_w = diff_w >>> 1;
        if (half_w > MAXV) begin
            result_o = MAXV[W-1:0];
        end else if (half_w < MINV) begin
            result_o = MINV[W-1:0];
        end else begin
            result_o = half_w[W-1:0];
        end
    end

    AST_POSITIVE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_done_i && ($signed(pos_q) > $signed(word_i))) |-> ($signed(result_o) > 0)); // R6
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_done_i && !pos_q[W-1] && word_i[W-1]) |-> !result_o[W-1]); // R7

endmodule

// File: rtl/ocs_out_stage.sv
module ocs_out_stage #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass_take_i,
    input  logic         pair_done_i,
    input  logic [W-1:0] pass_word_i,
    input  logic [W-1:0] pair_word_i,
    output logic [W-1:0] out_word_o,
    output logic         out_valid_o,
    output logic         irq_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_word_o  <= '0;
            out_valid_o <= 1'b0;
            irq_o       <= 1'b0;
        end else begin
            out_valid_o <= pass_take_i || pair_done_i;
            irq_o       <= pass_take_i || pair_done_i;
            if (pair_done_i) begin
                out_word_o <= pair_word_i;
            end else if (pass_take_i) begin
                out_word_o <= pass_word_i;
            end
        end
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_take_i && pair_done_i)); // R2
    AST_IRQ_TRACKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == out_valid_o); // R9

endmodule

// File: rtl/ocs_sequencer.sv
module ocs_sequencer #(
    parameter int W          = 24,
    parameter int SKIP_WORDS = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] flt_word_i,
    input  logic         flt_valid_i,
    output logic         polarity_o,
    output logic         short_o,
    output logic [W-1:0] out_word_o,
    output logic         out_valid_o,
    output logic         irq_o
);

    logic         pass_take;
    logic         pos_load;
    logic         pair_done;
    logic [W-1:0] pair_word;

    ocs_fsm #(.SKIP_WORDS(SKIP_WORDS)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .flt_valid_i (flt_valid_i),
        .pass_take_o (pass_take),
        .pos_load_o  (pos_load),
        .pair_done_o (pair_done),
        .polarity_o  (polarity_o),
        .short_o     (short_o)
    );

    ocs_pair_math #(.W(W)) i_math (
        .clk         (clk),
        .rst_n       (rst_n),
        .pos_load_i  (pos_load),
        .pair_done_i (pair_done),
        .word_i      (flt_word_i),
        .result_o    (pair_word)
    );

    ocs_out_stage #(.W(W)) i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pass_take_i (pass_take),
        .pair_done_i (pair_done),
        .pass_word_i (flt_word_i),
        .pair_word_i (pair_word),
        .out_word_o  (out_word_o),
        .out_valid_o (out_valid_o),
        .irq_o       (irq_o)
    );

    AST_OUT_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(flt_valid_i)); // R2
    AST_NO_OUT_AFTER_MODE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_i) |=> !out_valid_o); // R8

endmodule

// File: tb/test_ocs_sequencer.sv
module test_ocs_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b10;
    logic [23:0] flt_word = '0;
    logic        flt_valid = 1'b0;
    logic        polarity, short_fe, out_valid, irq;
    logic [23:0] out_word;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ocs_sequencer i_ocs_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode),
        .flt_word_i  (flt_word),
        .flt_valid_i (flt_valid),
        .polarity_o  (polarity),
        .short_o     (short_fe),
        .out_word_o  (out_word),
        .out_valid_o (out_valid),
        .irq_o       (irq)
    );

    // {pos, neg, expected}
    localparam logic [71:0] PAIRS [10] = '{
        {24'h000064, 24'h000028, 24'h00001E},
        {24'h000028, 24'h000064, 24'hFFFFE2},
        {24'h000007, 24'h000002, 24'h000003},
        {24'h000002, 24'h000007, 24'hFFFFFE},
        {24'h000000, 24'h000000, 24'h000000},
        {24'hFFFFFB, 24'hFFFFF6, 24'h000003},
        {24'h7FFFFF, 24'h800000, 24'h7FFFFF},
        {24'h800000, 24'h7FFFFF, 24'h800001},
        {24'h000001, 24'h000000, 24'h000001},
        {24'h000000, 24'h000001, 24'h000000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
    endtask

    task automatic push(input logic [23:0] w, output logic v, output logic [23:0] o, output logic q);
        @(negedge clk);
        flt_word  = w;
        flt_valid = 1'b1;
        @(negedge clk);
        flt_valid = 1'b0;
        v = out_valid;
        o = out_word;
        q = irq;
    endtask

    task automatic expect_none(input logic [23:0] w, input string req);
        logic v, q;
        logic [23:0] o;
        push(w, v, o, q);
        check(!v && !q, req, {30'd0, v, q}, 32'd0);
    endtask

    task automatic expect_word(input logic [23:0] w, input logic [23:0] exp, input string req);
        logic v, q;
        logic [23:0] o;
        push(w, v, o, q);
        check(v && (o == exp), req, {7'd0, v, o}, {8'h01, exp});
        check(q == v, {req, " R9 irq"}, {31'd0, q}, {31'd0, v});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic v, q;
        logic [23:0] o;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(short_fe && !polarity && !out_valid && !irq && out_word == 0, "R1 reset",
              {27'd0, short_fe, polarity, out_valid, irq, |out_word}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reserved mode
        expect_none(24'h123456, "R10 reserved word");
        check(short_fe && !polarity, "R10 shorted", {30'd0, short_fe, polarity}, 32'h2);

        // R2 shorted pass-through
        set_mode(2'b00);
        check(short_fe && !polarity, "R2 short", {30'd0, short_fe, polarity}, 32'h2);
        expect_none(24'hAAAAAA, "R5 settle drop mode00");
        expect_word(24'hFFFF10, 24'hFFFF10, "R2 pass a");
        expect_word(24'h000033, 24'h000033, "R2 pass b");

        // R3 signal pass-through
        set_mode(2'b11);
        check(!short_fe && !polarity, "R3 open", {30'd0, short_fe, polarity}, 32'h0);
        expect_none(24'h555555, "R5 settle drop mode11");
        expect_word(24'h400000, 24'h400000, "R3 pass a");
        expect_word(24'h800000, 24'h800000, "R3 pass b");

        // R8 mode change coinciding with a word in pass-through
        @(negedge clk);
        mode = 2'b00;
        flt_word = 24'h0F0F0F;
        flt_valid = 1'b1;
        @(negedge clk);
        flt_valid = 1'b0;
        check(!out_valid, "R8 change+word pass", {31'd0, out_valid}, 32'd0);

        // R4 R6 R7 cancelling pairs from table
        set_mode(2'b01);
        check(!short_fe && !polarity, "R4 entry", {30'd0, short_fe, polarity}, 32'h0);
        for (int i = 0; i < 10; i++) begin
            expect_none(24'h3C3C3C, "R5 settle before pos");
            expect_none(PAIRS[i][71:48], "R6 pos word no output");
            check(polarity, "R4 swapped after pos", {31'd0, polarity}, 32'd1);
            expect_none(24'hC3C3C3, "R5 settle after swap");
            expect_word(PAIRS[i][47:24], PAIRS[i][23:0], (i == 6) ? "R7 saturate" : "R6 pair result");
            check(!polarity, "R4 back to normal", {31'd0, polarity}, 32'd0);
        end

        // R8 mode change mid-pair together with a word
        expect_none(24'h000000, "R5 settle");
        expect_none(24'h700000, "R8 abandoned pos");
        check(polarity, "R4 swapped", {31'd0, polarity}, 32'd1);
        @(negedge clk);
        mode = 2'b11;
        flt_word = 24'h000001;
        flt_valid = 1'b1;
        @(negedge clk);
        flt_valid = 1'b0;
        check(!out_valid, "R8 change+word cancel", {31'd0, out_valid}, 32'd0);
        check(!polarity, "R8 polarity cleared", {31'd0, polarity}, 32'd0);
        set_mode(2'b01);
        check(!polarity, "R8 restart normal", {31'd0, polarity}, 32'd0);
        expect_none(24'h111111, "R5 settle restart");
        expect_none(24'h00000A, "R6 new pos");
        expect_none(24'h222222, "R5 settle swap");
        expect_word(24'h000004, 24'h000003, "R8 fresh pair result");

        // R4 polarity holds without words
        repeat (3) @(negedge clk);
        check(!polarity && !out_valid, "R4 hold idle", {30'd0, polarity, out_valid}, 32'd0);
        push(24'h0, v, o, q);
        check(!v, "R5 dropped", {31'd0, v}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule